// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates interrupt requests from a set of device groups on behalf of a processor. Each group has one request line and a fixed priority level. Group g, counted from 0, has level g+1, so the highest-numbered group ranks highest. The devices inside a group share that line. Within a group, the acknowledge runs down a chain that starts at the device nearest the processor. The block holds the processor's current priority level. It grants a request only when the group's level is strictly above that value. On a grant it raises the held level to the level of the granted group and pushes the old level onto a small internal stack.

A grant produces three outputs together: a one-cycle acknowledge pulse to the chosen device, a service-routine address built from that device's identifying code and a fixed base, and a valid strobe for that address. A return input pops the level that was saved last, so nested service unwinds in order. Software changes the level through a write port that carries a supervisor flag. A write made in user mode does not change the level and raises a privilege-exception pulse instead.

The vector output is a one-way stream with no back-pressure. The valid strobe is high for exactly one cycle per grant, and the processor must capture the address in that cycle. The block has no ready input, so it cannot stall. All other pins are plain control and status signals.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `cur_pri` is 0 and `dev_ack`, `vec_valid` and `priv_exc` are all low.
- R2: A device is bit i = g*DEVS_PER_GRP + d of `dev_req`/`dev_ien`, where g is its group (level g+1) and d is its position in the chain. A group competes only if its level is strictly greater than `cur_pri`. At level 0 any enabled request is accepted.
- R3: A grant is decided from the inputs and state in one cycle. After that clock edge, `cur_pri` equals the granted level and `dev_ack` and `vec_valid` are high for that one cycle.
- R4: When several eligible groups request in the same cycle, the group with the highest level is granted.
- R5: Within the granted group, the requesting device with the lowest position d wins. `dev_ack` never has more than one bit set.
- R6: A device whose `dev_ien` bit is 0 is never acknowledged, and its request has no effect on the grant.
- R7: When `pri_wr_en` is high and `pri_wr_sup` is low, `cur_pri` does not change and `priv_exc` pulses high in the next cycle.
- R8: When `pri_wr_en` and `pri_wr_sup` are both high and `rti` is low, `cur_pri` takes `pri_wr_data` after the edge.
- R9: When `rti` is high, `cur_pri` takes the most recently saved level. If no level has been saved, `cur_pri` keeps its value. No grant and no level write happen in a cycle with `rti`.
- R10: The vector is `VEC_BASE + (code << VEC_SHIFT)`, where code is the granted device's field at bits i*CODE_W of `dev_code`. It appears on `vec_addr` while `vec_valid` is high.
- R11: No grant happens in a cycle with `pri_wr_en` high, or when the saved-level stack already holds NUM_LVL entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | NUM_LVL*DEVS_PER_GRP | Raw service request from each device |
| dev_ien | input | NUM_LVL*DEVS_PER_GRP | Interrupt-enable bit of each device |
| dev_code | input | NUM_LVL*DEVS_PER_GRP*CODE_W | Identifying code of each device |
| pri_wr_en | input | 1 | Write strobe for the priority level |
| pri_wr_sup | input | 1 | Writer is in supervisor mode |
| pri_wr_data | input | LVL_W | New priority level |
| rti | input | 1 | Return from service; restore the saved level |
| cur_pri | output | LVL_W | Current processor priority level |
| dev_ack | output | NUM_LVL*DEVS_PER_GRP | One-cycle acknowledge to the granted device |
| vec_valid | output | 1 | Service address valid (no back-pressure) |
| vec_addr | output | VEC_W | Service-routine start address |
| priv_exc | output | 1 | Privilege-exception pulse |

## Verification
The assertions check several properties on every cycle. The acknowledge is never on more than one device. An acknowledged device must have had an enabled request in the cycle before. Every grant raises the level. A user-mode write leaves the level unchanged and raises the exception pulse. A return cycle never produces a grant. Other behaviour can only be shown by the bench's scenarios, which compare against an independent model of the saved-level stack. These behaviours are: choosing the highest eligible group and the nearest device, the exact vector arithmetic, the order in which nested levels unwind, a return with an empty stack, and grants blocked by a write or by a full stack.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_RET   = 2'd1,
    OP_WRITE = 2'd2,
    OP_GRANT = 2'd3
  } pri_op_e;
endpackage

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned N = 3
) (
  input  logic         ack_in,
  input  logic [N-1:0] req,
  output logic [N-1:0] ack_out
);
  logic [N:0] pass;
  assign pass[0] = ack_in;
  for (genvar i = 0; i < N; i++) begin : g_link
    assign ack_out[i]  = pass[i] & req[i];
    assign pass[i+1]   = pass[i] & ~req[i];
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] grp_req,
  input  logic [LVL_W-1:0]   cur_pri,
  output logic [NUM_LVL-1:0] grp_win,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               win_any
);
  always_comb begin
    grp_win = '0;
    win_lvl = '0;
    win_any = 1'b0;
    for (int g = 0; g < NUM_LVL; g++) begin
      if (grp_req[g] && (LVL_W'(g + 1) > cur_pri)) begin
        grp_win    = '0;
        grp_win[g] = 1'b1;
        win_lvl    = LVL_W'(g + 1);
        win_any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pri_stack.sv
module irq_pri_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] din,
  output logic [LVL_W-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);
  localparam int unsigned SLOTS = 2 ** PTR_W;

  logic [LVL_W-1:0] mem [SLOTS];
  logic [PTR_W-1:0] sp;

  assign empty = (sp == '0);
  assign full  = (sp == PTR_W'(DEPTH));
  assign dout  = empty ? '0 : mem[sp - PTR_W'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + PTR_W'(1);
    end else if (pop && !empty) begin
      sp <= sp - PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp] <= din;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LVL      = 4,
  parameter int unsigned DEVS_PER_GRP = 3,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned VEC_W        = 16,
  parameter int unsigned VEC_SHIFT    = 2,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0400,
  localparam int unsigned NUM_DEV     = NUM_LVL * DEVS_PER_GRP,
  localparam int unsigned LVL_W       = $clog2(NUM_LVL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DEV-1:0]        dev_req,
  input  logic [NUM_DEV-1:0]        dev_ien,
  input  logic [NUM_DEV*CODE_W-1:0] dev_code,
  input  logic                      pri_wr_en,
  input  logic                      pri_wr_sup,
  input  logic [LVL_W-1:0]          pri_wr_data,
  input  logic                      rti,
  output logic [LVL_W-1:0]          cur_pri,
  output logic [NUM_DEV-1:0]        dev_ack,
  output logic                      vec_valid,
  output logic [VEC_W-1:0]          vec_addr,
  output logic                      priv_exc
);
  logic [NUM_DEV-1:0] live_req;
  logic [NUM_DEV-1:0] sel_dev;
  logic [NUM_LVL-1:0] grp_req;
  logic [NUM_LVL-1:0] grp_win;
  logic [LVL_W-1:0]   win_lvl;
  logic               win_any;
  logic [LVL_W-1:0]   saved_lvl;
  logic               stk_empty;
  logic               stk_full;
  logic [CODE_W-1:0]  sel_code;
  logic [VEC_W-1:0]   next_vec;
  pri_op_e            op;

  assign live_req = dev_req & dev_ien;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_grp
    assign grp_req[g] = |live_req[g*DEVS_PER_GRP +: DEVS_PER_GRP];
    irq_daisy_chain #(.N(DEVS_PER_GRP)) u_chain (
      .ack_in (grp_win[g]),
      .req    (live_req[g*DEVS_PER_GRP +: DEVS_PER_GRP]),
      .ack_out(sel_dev[g*DEVS_PER_GRP +: DEVS_PER_GRP])
    );
  end

  irq_level_arb #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_arb (
    .grp_req(grp_req),
    .cur_pri(cur_pri),
    .grp_win(grp_win),
    .win_lvl(win_lvl),
    .win_any(win_any)
  );

  always_comb begin
    if (rti)                        op = OP_RET;
    else if (pri_wr_en)             op = OP_WRITE;
    else if (win_any && !stk_full)  op = OP_GRANT;
    else                            op = OP_IDLE;
  end

  irq_pri_stack #(.DEPTH(NUM_LVL), .LVL_W(LVL_W)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .push (op == OP_GRANT),
    .pop  (op == OP_RET),
    .din  (cur_pri),
    .dout (saved_lvl),
    .empty(stk_empty),
    .full (stk_full)
  );

  always_comb begin
    sel_code = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel_dev[i]) sel_code = sel_code | dev_code[i*CODE_W +: CODE_W];
    end
  end

  assign next_vec = VEC_BASE + (VEC_W'(sel_code) << VEC_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pri   <= '0;
      dev_ack   <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      priv_exc  <= 1'b0;
    end else begin
      priv_exc  <= pri_wr_en && !pri_wr_sup;
      dev_ack   <= '0;
      vec_valid <= 1'b0;
      unique case (op)
        OP_RET:   if (!stk_empty) cur_pri <= saved_lvl;
        OP_WRITE: if (pri_wr_sup) cur_pri <= pri_wr_data;
        OP_GRANT: begin
          cur_pri   <= win_lvl;
          dev_ack   <= sel_dev;
          vec_valid <= 1'b1;
          vec_addr  <= next_vec;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_DEV = 12,
  parameter int unsigned LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] dev_req,
  input logic [NUM_DEV-1:0] dev_ien,
  input logic               pri_wr_en,
  input logic               pri_wr_sup,
  input logic               rti,
  input logic [LVL_W-1:0]   cur_pri,
  input logic [NUM_DEV-1:0] dev_ack,
  input logic               vec_valid,
  input logic               priv_exc
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack)); // R5

  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |-> ((dev_ack & ~$past(dev_req & dev_ien)) == '0)); // R6

  AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (cur_pri > $past(cur_pri))); // R3

  AST_USER_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_wr_en && !pri_wr_sup && !rti) |=> $stable(cur_pri)); // R7

  AST_USER_WR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_wr_en && !pri_wr_sup) |=> priv_exc); // R7

  AST_RET_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rti |=> !vec_valid); // R9

  AST_WR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    pri_wr_en |=> (dev_ack == '0)); // R11
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_req   (dev_req),
  .dev_ien   (dev_ien),
  .pri_wr_en (pri_wr_en),
  .pri_wr_sup(pri_wr_sup),
  .rti       (rti),
  .cur_pri   (cur_pri),
  .dev_ack   (dev_ack),
  .vec_valid (vec_valid),
  .priv_exc  (priv_exc)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int NL = 4;
  localparam int DPG = 3;
  localparam int CW = 6;
  localparam int ND = NL * DPG;
  localparam int LW = 3;
  localparam logic [15:0] BASE = 16'h0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0] dev_req = '0, dev_ien = '0;
  logic [ND*CW-1:0] dev_code = '0;
  logic pri_wr_en = 1'b0, pri_wr_sup = 1'b0, rti = 1'b0;
  logic [LW-1:0] pri_wr_data = '0;
  logic [LW-1:0] cur_pri;
  logic [ND-1:0] dev_ack;
  logic vec_valid, priv_exc;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  int m_cur = 0;
  int m_sp = 0;
  int m_stk [8];

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ien(dev_ien),
    .dev_code(dev_code), .pri_wr_en(pri_wr_en), .pri_wr_sup(pri_wr_sup),
    .pri_wr_data(pri_wr_data), .rti(rti), .cur_pri(cur_pri),
    .dev_ack(dev_ack), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .priv_exc(priv_exc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [ND*CW-1:0] codes, input int dev);
    logic [CW-1:0] c;
    c = codes[dev*CW +: CW];
    return BASE + (16'(c) << 2);
  endfunction

  // One cycle: drive at the falling edge, predict, compare at the next falling edge.
  task automatic cyc(input logic [ND-1:0] rq, input logic [ND-1:0] en,
                     input logic wr, input logic sup, input int wd,
                     input logic rt, input string atag);
    logic [ND-1:0] live;
    int win_g, win_d;
    logic [ND-1:0] e_ack;
    logic e_vv, e_exc;
    logic [15:0] e_vec;
    string ptag;
    dev_req = rq; dev_ien = en; pri_wr_en = wr; pri_wr_sup = sup;
    pri_wr_data = LW'(wd); rti = rt;
    live = rq & en;
    win_g = -1; win_d = -1;
    for (int g = 0; g < NL; g++) begin
      if ((|live[g*DPG +: DPG]) && (g + 1 > m_cur)) win_g = g;
    end
    if (win_g >= 0) begin
      for (int d = DPG - 1; d >= 0; d--) if (live[win_g*DPG + d]) win_d = d;
    end
    e_ack = '0; e_vv = 1'b0; e_vec = '0;
    e_exc = wr && !sup;
    ptag = "R2";
    if (rt) begin
      ptag = "R9";
      if (m_sp > 0) begin m_sp--; m_cur = m_stk[m_sp]; end
    end else if (wr) begin
      ptag = sup ? "R8" : "R7";
      if (sup) m_cur = wd;
    end else if (win_g >= 0 && m_sp < NL) begin
      ptag = "R3";
      m_stk[m_sp] = m_cur; m_sp++;
      m_cur = win_g + 1;
      e_ack[win_g*DPG + win_d] = 1'b1;
      e_vv = 1'b1;
      e_vec = vec_of(dev_code, win_g*DPG + win_d);
    end else if (win_g >= 0) begin
      ptag = "R11";
    end
    @(posedge clk);
    @(negedge clk);
    chk({ptag, " cur_pri"}, 32'(cur_pri), 32'(m_cur));
    chk({atag, " dev_ack"}, 32'(dev_ack), 32'(e_ack));
    chk({ptag, " vec_valid"}, 32'(vec_valid), 32'(e_vv));
    if (e_vv) chk("R10 vec_addr", 32'(vec_addr), 32'(e_vec));
    chk("R7 priv_exc", 32'(priv_exc), 32'(e_exc));
  endtask

  localparam logic [ND-1:0] ALL = '1;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ND; i++) dev_code[i*CW +: CW] = CW'($urandom);
    repeat (3) @(negedge clk);
    chk("R1 cur_pri", 32'(cur_pri), 0);
    chk("R1 dev_ack", 32'(dev_ack), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 priv_exc", 32'(priv_exc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // level 0 takes a group-0 request
    cyc(ND'(1) << 1, ALL, 0, 0, 0, 0, "R2");
    // groups 1 and 3 together: group 3 wins (R4)
    cyc((ND'(1) << 3) | (ND'(1) << 11), ALL, 0, 0, 0, 0, "R4");
    // group 2 does not outrank level 4
    cyc(ND'(1) << 6, ALL, 0, 0, 0, 0, "R2");
    chk("R2 held level", 32'(cur_pri), 4);
    // unwind twice, then return on an empty stack
    cyc('0, ALL, 0, 0, 0, 1, "R9");
    cyc('0, ALL, 0, 0, 0, 1, "R9");
    cyc('0, ALL, 0, 0, 0, 1, "R9");
    chk("R9 empty return", 32'(cur_pri), 0);
    // chain: devices 1 and 2 of group 2, nearest wins
    cyc((ND'(1) << 7) | (ND'(1) << 8), ALL, 0, 0, 0, 0, "R5");
    // supervisor write back to 0
    cyc('0, ALL, 1, 1, 0, 0, "R8");
    // disabled device 0 of group 1 is passed over
    cyc((ND'(1) << 3) | (ND'(1) << 5), ALL & ~(ND'(1) << 3), 0, 0, 0, 0, "R6");
    cyc('0, ALL, 0, 0, 0, 1, "R9");
    // only a disabled request: nothing
    cyc(ND'(1) << 9, ALL & ~(ND'(1) << 9), 0, 0, 0, 0, "R6");
    // user write is blocked and flagged
    cyc('0, ALL, 1, 0, 4, 0, "R7");
    chk("R7 level kept", 32'(cur_pri), 0);
    // a write cycle blocks a pending grant
    cyc(ND'(1) << 0, ALL, 1, 1, 0, 0, "R11");
    // fill the stack via repeated lowering, then a grant is blocked
    for (int k = 0; k < NL; k++) begin
      cyc(ND'(1) << 9, ALL, 0, 0, 0, 0, "R3");
      cyc('0, ALL, 1, 1, 0, 0, "R8");
    end
    cyc(ND'(1) << 9, ALL, 0, 0, 0, 0, "R11");
    chk("R11 full stack", 32'(vec_valid), 0);
    for (int k = 0; k < NL + 1; k++) cyc('0, ALL, 0, 0, 0, 1, "R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [ND-1:0] rq, en;
      logic wr, sup, rt;
      rq = ND'($urandom & $urandom & $urandom);
      en = ND'(~($urandom & $urandom));
      wr = ($urandom % 10) == 0;
      sup = ($urandom % 4) != 0;
      rt = ($urandom % 6) == 0;
      if (n % 50 == 0) for (int i = 0; i < ND; i++) dev_code[i*CW +: CW] = CW'($urandom);
      cyc(rq, en, wr, sup, int'($urandom % (NL + 1)), rt, "R5");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule